// File: doc/BRIEF.md
# Buffered Down-Counting PWM Timer Bank

This block holds a small bank of down-counting timers that share one register port. Each timer has a period buffer and a compare buffer. Software writes them at any time. The live counter and live compare registers take the buffered values only at an underflow or during a forced load. Because of this, a reprogrammed period never tears the waveform that is already running. Each timer counts one step for every pulse on its own tick enable input. When it passes through zero it raises a one-cycle underflow pulse. It then either reloads from its buffers and keeps going, or it parks at zero.

All but the last timer drive a PWM level. The level is active while the live count is at or below the live compare value, and a per-channel invert bit can flip it. The last timer is a pure interval timer with no output. The per-channel control fields share one control word. Channel 0 occupies the lowest nibble. The nibble just above it is left empty. Every later channel n sits in nibble n+1. The last channel has no invert bit, so its auto-reload flag moves down into that bit position. Software drives a forced load by setting the channel's load bit on one write and clearing it on the next.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset, every register reads zero, every PWM output is 0 and no underflow pulse is raised.
- R2: The control word is at byte address 0x08. The period buffer of channel n is at 0x0C+12n and its compare buffer is at 0x10+12n. A buffer keeps the low 16 bits of a write and reads back zero-extended. Any other address reads 0 and ignores writes.
- R3: Channel 0 uses control bits 3:0, and channel n≥1 uses bits 4(n+1)+3:4(n+1). Within a nibble, bit 0 is run, bit 1 is forced load and bit 2 is invert. On every channel except the last, bit 3 is auto-reload. The last channel (4) has auto-reload at bit 2 and has no invert bit. Bits 7:4, bit 23 and any bits above it read 0. With default parameters, writing all ones reads back 0x007FFF0F.
- R4: On each tick, a running channel with a nonzero count decrements it by one. With auto-reload set, a period buffer value N gives a period of N+1 ticks.
- R5: While a channel's forced-load bit is 1, its live count and compare registers copy the buffers on every clock, and ticks have no effect.
- R6: A tick that finds a running channel at count 0 raises that channel's underflow output for exactly the next clock cycle. If auto-reload is set, the same tick copies both buffers into the live registers.
- R7: With auto-reload clear, the channel stays at 0 after its underflow. It raises no further pulses and its output sits at the inactive level until a forced load is made or run is cleared.
- R8: The uninverted level is 1 while the live count is at or below the live compare value. A compare value M ≤ N therefore gives M+1 high ticks per N+1 tick period, and a compare of 0xFFFF gives 100% duty.
- R9: The PWM output is the level XOR the invert bit. A stopped channel outputs its invert bit.
- R10: Writing a buffer in mid-period leaves the current period unchanged. The new values apply from the next underflow.
- R11: Ticks to a channel whose run bit is 0 change neither its count nor its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte address for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr, combinational |
| tick | input | 5 | Per-channel count enable |
| pwm_out | output | 4 | PWM levels of channels 0 to 3 |
| underflow | output | 5 | Per-channel underflow pulse |

## Verification
A bad live count shows up on the PWM output at the tick where the count crosses the compare value. At the latest it shows up as an underflow pulse that arrives early or late, so one period reveals it. A control bit decoded from the wrong position shows up as a channel that does not run, does not reload or is wrongly inverted, and it does so on the first tick. A buffer that leaks into the live registers outside a reload changes the duty within the period in which it is written. The sweep compares every output after every tick with a count computed in the bench, so each of these faults is caught within one period.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  typedef struct packed {
    logic start;
    logic manual;
    logic invert;
    logic autoreload;
  } chan_ctl_t;

  // control nibble used by a channel: one empty nibble follows channel 0
  function automatic int nibble_of(input int ch);
    return (ch == 0) ? 0 : ch + 1;
  endfunction

  // position of the auto-reload flag inside a nibble
  function automatic int reload_pos(input int ch, input int nch);
    return (ch == nch - 1) ? 2 : 3;
  endfunction

  function automatic logic [63:0] ctrl_mask(input int nch);
    logic [63:0] m;
    m = '0;
    for (int c = 0; c < nch; c++) begin
      m[4*nibble_of(c)]     = 1'b1;
      m[4*nibble_of(c) + 1] = 1'b1;
      if (c != nch - 1) m[4*nibble_of(c) + 2] = 1'b1;
      m[4*nibble_of(c) + reload_pos(c, nch)] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH     = 5,
  parameter int CNT_W      = 16,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int CTRL_ADDR  = 8,
  parameter int BUF_BASE   = 12,
  parameter int BUF_STRIDE = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [DATA_W-1:0]            rd_data,
  output chan_ctl_t [NUM_CH-1:0]       ctl_o,
  output logic [NUM_CH-1:0][CNT_W-1:0] cnt_buf_o,
  output logic [NUM_CH-1:0][CNT_W-1:0] cmp_buf_o
);

  localparam int CTRL_W = 4 * (NUM_CH + 1);
  localparam logic [CTRL_W-1:0] CTRL_MASK = CTRL_W'(ctrl_mask(NUM_CH));

  logic [CTRL_W-1:0]            ctrl_q, ctrl_d;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_buf_q, cnt_buf_d;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_buf_q, cmp_buf_d;
  logic                         wr_unused_bits;

  assign wr_unused_bits = ^wr_data[DATA_W-1:CTRL_W];

  always_comb begin
    ctrl_d    = ctrl_q;
    cnt_buf_d = cnt_buf_q;
    cmp_buf_d = cmp_buf_q;
    if (wr_en) begin
      if (addr == ADDR_W'(CTRL_ADDR)) ctrl_d = wr_data[CTRL_W-1:0] & CTRL_MASK;
      for (int c = 0; c < NUM_CH; c++) begin
        if (addr == ADDR_W'(BUF_BASE + BUF_STRIDE*c))     cnt_buf_d[c] = wr_data[CNT_W-1:0];
        if (addr == ADDR_W'(BUF_BASE + BUF_STRIDE*c + 4)) cmp_buf_d[c] = wr_data[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      cnt_buf_q <= '0;
      cmp_buf_q <= '0;
    end else begin
      ctrl_q    <= ctrl_d;
      cnt_buf_q <= cnt_buf_d;
      cmp_buf_q <= cmp_buf_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(CTRL_ADDR)) rd_data = DATA_W'(ctrl_q);
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ADDR_W'(BUF_BASE + BUF_STRIDE*c))     rd_data = DATA_W'(cnt_buf_q[c]);
      if (addr == ADDR_W'(BUF_BASE + BUF_STRIDE*c + 4)) rd_data = DATA_W'(cmp_buf_q[c]);
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      ctl_o[c].start      = ctrl_q[4*nibble_of(c)];
      ctl_o[c].manual     = ctrl_q[4*nibble_of(c) + 1];
      ctl_o[c].invert     = (c == NUM_CH - 1) ? 1'b0 : ctrl_q[4*nibble_of(c) + 2];
      ctl_o[c].autoreload = ctrl_q[4*nibble_of(c) + reload_pos(c, NUM_CH)];
    end
  end

  assign cnt_buf_o = cnt_buf_q;
  assign cmp_buf_o = cmp_buf_q;

  // R3
  ctrl_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(CTRL_ADDR)) |-> (rd_data[7:4] == 4'b0 && rd_data[DATA_W-1] == 1'b0));

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  chan_ctl_t        ctl_i,
  input  logic [CNT_W-1:0] cnt_buf_i,
  input  logic [CNT_W-1:0] cmp_buf_i,
  output logic             level_o,
  output logic             underflow_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             halted_q, halted_d;
  logic             uf_q, uf_d;
  logic             active;

  assign active = ctl_i.start & ~halted_q;

  always_comb begin
    cnt_d    = cnt_q;
    cmp_d    = cmp_q;
    halted_d = halted_q;
    uf_d     = 1'b0;
    if (ctl_i.manual) begin
      cnt_d    = cnt_buf_i;
      cmp_d    = cmp_buf_i;
      halted_d = 1'b0;
    end else if (!ctl_i.start) begin
      halted_d = 1'b0;
    end else if (tick_i && !halted_q) begin
      if (cnt_q == '0) begin
        uf_d = 1'b1;
        if (ctl_i.autoreload) begin
          cnt_d = cnt_buf_i;
          cmp_d = cmp_buf_i;
        end else begin
          halted_d = 1'b1;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      cmp_q    <= '0;
      halted_q <= 1'b0;
      uf_q     <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      cmp_q    <= cmp_d;
      halted_q <= halted_d;
      uf_q     <= uf_d;
    end
  end

  assign level_o     = ctl_i.invert ^ (active & (cnt_q <= cmp_q));
  assign underflow_o = uf_q;

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick_i && !ctl_i.manual && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R5
  manual_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_i.manual |=> (cnt_q == $past(cnt_buf_i) && cmp_q == $past(cmp_buf_i)));

  // R6
  uf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> ($past(tick_i) && $past(cnt_q) == '0));

  // R7
  halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && ctl_i.start && !ctl_i.manual) |=> (!underflow_o && $stable(cnt_q)));

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NUM_CH-1:0] tick,
  output logic [NUM_CH-2:0] pwm_out,
  output logic [NUM_CH-1:0] underflow
);

  logic [1:0]                   rst_sync_q;
  logic                         rst_core_n;
  chan_ctl_t [NUM_CH-1:0]       ctl;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_buf;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_buf;
  logic [NUM_CH-1:0]            level_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  pwm_bank_regs #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .ctl_o(ctl),
    .cnt_buf_o(cnt_buf), .cmp_buf_o(cmp_buf)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pwm_bank_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_core_n), .tick_i(tick[c]), .ctl_i(ctl[c]),
      .cnt_buf_i(cnt_buf[c]), .cmp_buf_i(cmp_buf[c]),
      .level_o(level_all[c]), .underflow_o(underflow[c])
    );

    // R9
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
      !ctl[c].start |-> (level_all[c] == ctl[c].invert));
  end

  assign pwm_out = level_all[NUM_CH-2:0];

endmodule

// File: tb/pwm_timer_bank_test.sv
module pwm_timer_bank_test;
  localparam int NCH = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [7:0]      addr = '0;
  logic [31:0]     wr_data = '0;
  logic [31:0]     rd_data;
  logic [NCH-1:0]  tick = '0;
  logic [NCH-2:0]  pwm_out;
  logic [NCH-1:0]  underflow;

  int checks = 0;
  int errors = 0;
  int e_cnt [NCH];
  int e_cmp [NCH];
  int b_cnt [NCH];
  int b_cmp [NCH];
  bit e_st [NCH];
  bit e_ar [NCH];
  bit e_inv [NCH];
  bit e_halt [NCH];

  always #4 clk = ~clk;

  pwm_timer_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .pwm_out(pwm_out), .underflow(underflow)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic reg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = 8'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = 8'(a);
    #1;
    d = rd_data;
  endtask

  function automatic logic [31:0] ctrl_word(input int man_ch);
    logic [31:0] w;
    w = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      int b;
      b = 4 * ((ch == 0) ? 0 : ch + 1);
      w[b]     = e_st[ch];
      w[b + 1] = (ch == man_ch);
      if (ch < NCH - 1) begin
        w[b + 2] = e_inv[ch];
        w[b + 3] = e_ar[ch];
      end else begin
        w[b + 2] = e_ar[ch];
      end
    end
    return w;
  endfunction

  task automatic apply_ctrl(input int man_ch);
    reg_write(8, ctrl_word(man_ch));
    for (int ch = 0; ch < NCH; ch++) begin
      if (!e_st[ch]) e_halt[ch] = 1'b0;
      if (ch == man_ch) begin
        e_cnt[ch] = b_cnt[ch]; e_cmp[ch] = b_cmp[ch]; e_halt[ch] = 1'b0;
      end
    end
    if (man_ch >= 0) reg_write(8, ctrl_word(-1));
    else @(negedge clk);
  endtask

  task automatic set_buf(input int ch, input int n, input int m);
    reg_write(12 + 12*ch, 32'(n));
    reg_write(16 + 12*ch, 32'(m));
    b_cnt[ch] = n; b_cmp[ch] = m;
  endtask

  function automatic bit exp_level(input int ch);
    return e_inv[ch] ^ (e_st[ch] && !e_halt[ch] && e_cnt[ch] <= e_cmp[ch]);
  endfunction

  task automatic check_levels(input string req);
    for (int ch = 0; ch < NCH - 1; ch++)
      check(pwm_out[ch] == exp_level(ch), req, pwm_out[ch], exp_level(ch));
  endtask

  task automatic step(input int ch, input string req);
    logic [NCH-1:0] exp_v;
    @(negedge clk); tick[ch] = 1'b1;
    @(negedge clk); tick[ch] = 1'b0;
    exp_v = '0;
    if (e_st[ch] && !e_halt[ch]) begin
      if (e_cnt[ch] == 0) begin
        exp_v[ch] = 1'b1;
        if (e_ar[ch]) begin
          e_cnt[ch] = b_cnt[ch]; e_cmp[ch] = b_cmp[ch];
        end else begin
          e_halt[ch] = 1'b1;
        end
      end else begin
        e_cnt[ch]--;
      end
    end
    check(underflow == exp_v, req, underflow, exp_v);
    check_levels(req);
    @(negedge clk);
    check(underflow == '0, req, underflow, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int mlist [6];
    mlist = '{0, 1, 2, 3, 5, 65535};
    for (int ch = 0; ch < NCH; ch++) begin
      e_cnt[ch] = 0; e_cmp[ch] = 0; b_cnt[ch] = 0; b_cmp[ch] = 0;
      e_st[ch] = 0; e_ar[ch] = 0; e_inv[ch] = 0; e_halt[ch] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 80; a += 4) begin
      reg_read(a, d);
      check(d == 0, "R1", d, 0);
    end
    check(pwm_out == '0, "R1", pwm_out, 0);
    check(underflow == '0, "R1", underflow, 0);

    // R3 control layout readback
    reg_write(8, 32'hFFFF_FFFF);
    reg_read(8, d);
    check(d == 32'h007F_FF0F, "R3", d, 32'h007F_FF0F);
    reg_write(8, 32'h0);
    reg_read(8, d);
    check(d == 0, "R3", d, 0);

    // R2 buffer addresses, width and unmapped address
    for (int ch = 0; ch < NCH; ch++) begin
      reg_write(12 + 12*ch, 32'hABCD_0000 | 32'(ch*273 + 1));
      reg_write(16 + 12*ch, 32'h1234_0000 | 32'(ch*546 + 7));
    end
    for (int ch = 0; ch < NCH; ch++) begin
      reg_read(12 + 12*ch, d);
      check(d == 32'(ch*273 + 1), "R2", d, ch*273 + 1);
      reg_read(16 + 12*ch, d);
      check(d == 32'(ch*546 + 7), "R2", d, ch*546 + 7);
      b_cnt[ch] = ch*273 + 1; b_cmp[ch] = ch*546 + 7;
    end
    reg_write(4, 32'hFFFF_FFFF);
    reg_read(4, d);
    check(d == 0, "R2", d, 0);
    check_levels("R2");

    // R4 R6 R8 R9 sweep over period, compare and polarity
    for (int ch = 0; ch < NCH - 1; ch++) begin
      for (int n = 0; n < 4; n++) begin
        foreach (mlist[k]) begin
          set_buf(ch, n, mlist[k]);
          e_st[ch] = 0; e_ar[ch] = 1; e_inv[ch] = bit'((n + k) & 1);
          apply_ctrl(ch);
          check_levels("R9");
          e_st[ch] = 1;
          apply_ctrl(-1);
          check_levels("R8");
          for (int s = 0; s < 2*(n + 1) + 1; s++) step(ch, "R4/R6/R8");
          e_st[ch] = 0;
          apply_ctrl(-1);
          check_levels("R9");
        end
      end
    end

    // R10 buffer write in mid-period
    set_buf(2, 5, 2);
    e_st[2] = 0; e_ar[2] = 1; e_inv[2] = 0;
    apply_ctrl(2);
    e_st[2] = 1; apply_ctrl(-1);
    step(2, "R10"); step(2, "R10");
    set_buf(2, 1, 0);
    for (int s = 0; s < 9; s++) step(2, "R10");

    // R5 forced load restarts a running period
    set_buf(0, 3, 1);
    e_st[0] = 1; e_ar[0] = 1; e_inv[0] = 0;
    apply_ctrl(0);
    step(0, "R5"); step(0, "R5");
    apply_ctrl(0);
    check_levels("R5");
    for (int s = 0; s < 5; s++) step(0, "R5");

    // R7 one-shot stops at zero
    set_buf(1, 2, 1);
    e_st[1] = 1; e_ar[1] = 0; e_inv[1] = 1;
    apply_ctrl(1);
    for (int s = 0; s < 6; s++) step(1, "R7");
    check(pwm_out[1] == 1'b1, "R7", pwm_out[1], 1);

    // R11 ticks ignored while run is clear
    set_buf(3, 3, 0);
    e_st[3] = 0; e_ar[3] = 1; e_inv[3] = 1;
    apply_ctrl(3);
    for (int s = 0; s < 3; s++) step(3, "R11");
    e_st[3] = 1; apply_ctrl(-1);
    for (int s = 0; s < 5; s++) step(3, "R11");

    // R3 last channel reloads from bit 2 of its nibble
    set_buf(4, 1, 0);
    e_st[4] = 1; e_ar[4] = 1;
    apply_ctrl(4);
    for (int s = 0; s < 5; s++) step(4, "R3");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule